// File: doc/BRIEF.md
# UART Receiver With Per-Byte Error Flags

This block is the receive half of one asynchronous serial channel. It takes the raw RX pin and a one-cycle tick that runs at sixteen times the baud rate. A falling edge on the line is confirmed as a start bit at the middle of that bit. The byte is then rebuilt from samples taken at the middle of each bit, least significant bit first. An optional parity bit and one or two stop bits follow.

Each finished byte goes into a small receive FIFO. Three error bits travel with it: parity error, frame error and line break. The oldest entry of the FIFO is presented at the read side and leaves it on a pop. The flags of the head entry, together with a not-empty bit, are placed at fixed positions of an 8-bit status vector, which a neighbouring status register takes as it is. Line settings are applied live: parity enable, the 2-bit parity mode, the stop length and a receive-off bit.

Top module: `uart_rx_errchk`

## Requirements
- R1: After reset the FIFO is empty (`rx_count` = 0), `fifo_status` is 0 and `rd_data`, `rd_perr`, `rd_ferr` and `rd_brk` are 0.
- R2: With parity off and one stop bit, a frame of one low start bit, eight data bits sent least significant first and a high stop bit stores the byte with all three error flags clear.
- R3: When `par_en` is 1, the bit after the eighth data bit is taken as parity. It is checked according to `par_mode`: 2'b00 expects 0, 2'b01 expects odd parity over data plus parity bit, 2'b10 expects even parity, and 2'b11 expects 1. A mismatch sets the byte's parity-error flag.
- R4: When `par_en` is 0, no parity bit is expected: the bit after the eighth data bit is the stop bit, and the parity-error flag is always 0.
- R5: When `two_stop` is 1, two stop bits are sampled, and a low second stop bit alone sets the frame-error flag.
- R6: A stop bit that samples low sets the byte's frame-error flag.
- R7: A frame whose data bits, parity bit (if enabled) and stop bits are all low sets the line-break flag as well as the frame-error flag. A low level held for many bit times then yields exactly one entry, because the receiver waits for the line to go high before it looks for the next start bit.
- R8: A low pulse on the line that has ended before the middle of the start bit is rejected, and no entry is stored.
- R9: While `rx_disable` is 1, no frame is started and no byte is stored.
- R10: The FIFO returns entries in arrival order. When it holds `FIFO_DEPTH` entries, a newly received byte is dropped and the stored contents and count stay unchanged.
- R11: `fifo_status` bit 3 is 1 when the FIFO is not empty. Bits 4, 5 and 6 are the parity-error, frame-error and line-break flags of the head entry. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle pulse at 16x baud rate |
| rx_in | input | 1 | Serial receive line, idle high |
| rx_disable | input | 1 | 1 discards reception, 0 enables it |
| par_en | input | 1 | 1 expects and checks a parity bit |
| par_mode | input | 2 | Parity mode: 00 zero, 01 odd, 10 even, 11 one |
| two_stop | input | 1 | 1 selects two stop bits, 0 selects one |
| pop | input | 1 | Removes the head entry of the FIFO |
| rd_data | output | 8 | Data byte of the head entry (0 when empty) |
| rd_perr | output | 1 | Parity-error flag of the head entry |
| rd_ferr | output | 1 | Frame-error flag of the head entry |
| rd_brk | output | 1 | Line-break flag of the head entry |
| rx_count | output | $clog2(FIFO_DEPTH+1) | Number of stored entries |
| fifo_status | output | 8 | Status vector: bit 3 not empty, bits 4/5/6 head parity/frame/break |

## Verification
The bench drives all four parity modes with both correct and wrong parity bits. A design with the odd and even senses swapped, or with the forced modes ignored, gets the parity-error flag wrong on about half of these frames. It sends frames with only the first or only the second stop bit low, and an all-zero frame both with and without parity. A receiver that ties break to a zero data byte alone, or that skips the second stop bit, misreports these frames. A line held low for thirty bit times catches a receiver that re-arms at once and fills the FIFO with break entries. A short start glitch, reception turned off and a fifth byte into a four-deep FIFO catch designs that store noise, ignore the off bit, or overwrite the oldest entry.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   localparam int RX_DATA_W = 8;

   typedef enum logic [1:0] {
      PAR_ZERO = 2'b00,
      PAR_ODD  = 2'b01,
      PAR_EVEN = 2'b10,
      PAR_ONE  = 2'b11
   } par_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP1,
      ST_STOP2,
      ST_RECOVER
   } rx_state_e;

   typedef struct packed {
      logic                 brk;
      logic                 ferr;
      logic                 perr;
      logic [RX_DATA_W-1:0] data;
   } rx_word_t;

   localparam int RX_WORD_W = $bits(rx_word_t);

   // expected value of the parity bit for a given mode and data byte
   function automatic logic expected_parity(input par_mode_e mode,
                                            input logic [RX_DATA_W-1:0] d);
      logic p;
      case (mode)
         PAR_ZERO: p = 1'b0;
         PAR_ODD:  p = ~(^d);
         PAR_EVEN: p = ^d;
         default:  p = 1'b1;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int STAGES   = 2,
   parameter bit IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);

   initial begin
      assert (STAGES >= 0 && STAGES <= 4)
         else $fatal(1, "uart_rx_sync: STAGES must be 0..4");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign d_out = d_in;
      end else if (STAGES == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= IDLE_LVL;
            else        q <= d_in;
         end
         assign d_out = q;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= {STAGES{IDLE_LVL}};
            else        sr <= {sr[STAGES-2:0], d_in};
         end
         assign d_out = sr[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
   import uart_rx_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      rx_s,
   input  logic      start_en,
   input  logic      par_en,
   input  par_mode_e par_mode,
   input  logic      two_stop,
   output logic      done,
   output rx_word_t  word
);

   localparam int CNT_W = $clog2(OVS);
   localparam int IDX_W = $clog2(RX_DATA_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
   localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVS / 2 - 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(RX_DATA_W - 1);

   initial begin
      assert (OVS >= 4 && (OVS % 2) == 0)
         else $fatal(1, "uart_rx_frame: OVS must be even and at least 4");
   end

   rx_state_e               state;
   logic [CNT_W-1:0]        os_cnt;
   logic [IDX_W-1:0]        bit_idx;
   logic [RX_DATA_W-1:0]    shreg;
   logic                    par_q;
   logic                    ferr_q;
   logic                    zero_q;

   // values that close a frame at the final stop sample
   logic stop_ferr, stop_zero, perr_c, at_end;
   assign at_end    = (os_cnt == CNT_LAST);
   assign stop_ferr = ferr_q | ~rx_s;
   assign stop_zero = zero_q & ~rx_s;
   assign perr_c    = par_en & (par_q != expected_parity(par_mode, shreg));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         os_cnt  <= '0;
         bit_idx <= '0;
         shreg   <= '0;
         par_q   <= 1'b0;
         ferr_q  <= 1'b0;
         zero_q  <= 1'b0;
         done    <= 1'b0;
         word    <= '0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            case (state)
               ST_IDLE: begin
                  if (start_en && !rx_s) begin
                     state  <= ST_START;
                     os_cnt <= '0;
                  end
               end
               ST_START: begin
                  if (os_cnt == CNT_MID) begin
                     os_cnt <= '0;
                     if (!rx_s) begin
                        state   <= ST_DATA;
                        bit_idx <= '0;
                        ferr_q  <= 1'b0;
                        zero_q  <= 1'b1;
                        par_q   <= 1'b0;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else begin
                     os_cnt <= os_cnt + 1'b1;
                  end
               end
               ST_DATA: begin
                  if (at_end) begin
                     os_cnt <= '0;
                     shreg  <= {rx_s, shreg[RX_DATA_W-1:1]};
                     if (rx_s) zero_q <= 1'b0;
                     if (bit_idx == IDX_LAST) begin
                        state <= par_en ? ST_PAR : ST_STOP1;
                     end else begin
                        bit_idx <= bit_idx + 1'b1;
                     end
                  end else begin
                     os_cnt <= os_cnt + 1'b1;
                  end
               end
               ST_PAR: begin
                  if (at_end) begin
                     os_cnt <= '0;
                     par_q  <= rx_s;
                     if (rx_s) zero_q <= 1'b0;
                     state  <= ST_STOP1;
                  end else begin
                     os_cnt <= os_cnt + 1'b1;
                  end
               end
               ST_STOP1: begin
                  if (at_end) begin
                     os_cnt <= '0;
                     if (two_stop) begin
                        ferr_q <= stop_ferr;
                        zero_q <= stop_zero;
                        state  <= ST_STOP2;
                     end else begin
                        done       <= 1'b1;
                        word.data  <= shreg;
                        word.perr  <= perr_c;
                        word.ferr  <= stop_ferr;
                        word.brk   <= stop_zero;
                        state      <= rx_s ? ST_IDLE : ST_RECOVER;
                     end
                  end else begin
                     os_cnt <= os_cnt + 1'b1;
                  end
               end
               ST_STOP2: begin
                  if (at_end) begin
                     os_cnt     <= '0;
                     done       <= 1'b1;
                     word.data  <= shreg;
                     word.perr  <= perr_c;
                     word.ferr  <= stop_ferr;
                     word.brk   <= stop_zero;
                     state      <= rx_s ? ST_IDLE : ST_RECOVER;
                  end else begin
                     os_cnt <= os_cnt + 1'b1;
                  end
               end
               ST_RECOVER: begin
                  if (rx_s) state <= ST_IDLE;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_brk_implies_ferr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done && word.brk |-> word.ferr);

   p_idle_needs_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) && !tick |=> state == ST_IDLE);

   p_off_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) && !start_en |=> state == ST_IDLE);

   p_no_perr_without_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done && !$past(par_en) |-> !word.perr);

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 11
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        push,
   input  logic [W-1:0]                push_word,
   input  logic                        pop,
   output logic [W-1:0]                head,
   output logic [$clog2(DEPTH+1)-1:0]  count,
   output logic                        empty,
   output logic                        full
);

   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

   initial begin
      assert (DEPTH >= 2 && DEPTH <= 256)
         else $fatal(1, "uart_rx_fifo: DEPTH must be 2..256");
      assert (W >= 1)
         else $fatal(1, "uart_rx_fifo: W must be positive");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CNT_FULL);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign head    = mem[rd_ptr];

   generate
      if ((1 << PTR_W) == DEPTH) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_FULL);

   p_full_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
      full && push && !pop |=> count == $past(count));

   p_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      empty && pop && !push |=> empty);

endmodule

// File: rtl/uart_rx_errchk.sv
module uart_rx_errchk
   import uart_rx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int FIFO_DEPTH  = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             os_tick,
   input  logic                             rx_in,
   input  logic                             rx_disable,
   input  logic                             par_en,
   input  logic [1:0]                       par_mode,
   input  logic                             two_stop,
   input  logic                             pop,
   output logic [7:0]                       rd_data,
   output logic                             rd_perr,
   output logic                             rd_ferr,
   output logic                             rd_brk,
   output logic [$clog2(FIFO_DEPTH+1)-1:0]  rx_count,
   output logic [7:0]                       fifo_status
);

   localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

   initial begin
      assert (RX_DATA_W == 8)
         else $fatal(1, "uart_rx_errchk: byte-wide data expected");
   end

   logic     rx_s;
   logic     frm_done;
   rx_word_t frm_word;
   logic [RX_WORD_W-1:0] head_bits;
   rx_word_t head_word;
   logic     fifo_empty, fifo_full;
   logic [CNT_W-1:0] cnt;

   uart_rx_sync #(
      .STAGES   (SYNC_STAGES),
      .IDLE_LVL (1'b1)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (rx_in),
      .d_out (rx_s)
   );

   uart_rx_frame #(
      .OVS (OVS)
   ) i_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (os_tick),
      .rx_s     (rx_s),
      .start_en (~rx_disable),
      .par_en   (par_en),
      .par_mode (par_mode_e'(par_mode)),
      .two_stop (two_stop),
      .done     (frm_done),
      .word     (frm_word)
   );

   uart_rx_fifo #(
      .DEPTH (FIFO_DEPTH),
      .W     (RX_WORD_W)
   ) i_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (frm_done & ~rx_disable),
      .push_word (frm_word),
      .pop       (pop),
      .head      (head_bits),
      .count     (cnt),
      .empty     (fifo_empty),
      .full      (fifo_full)
   );

   // head entry is masked while the FIFO is empty so the read side is clean
   assign head_word = fifo_empty ? '0 : rx_word_t'(head_bits);
   assign rd_data   = head_word.data;
   assign rd_perr   = head_word.perr;
   assign rd_ferr   = head_word.ferr;
   assign rd_brk    = head_word.brk;
   assign rx_count  = cnt;

   // bit positions fixed by the status register that consumes this vector
   assign fifo_status = {1'b0, head_word.brk, head_word.ferr, head_word.perr,
                         ~fifo_empty, 3'b000};

   p_disabled_discard_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_disable && !pop |=> rx_count <= $past(rx_count));

   p_full_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full && !pop |=> rx_count == $past(rx_count));

   p_status_nonempty_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_status[3] == (rx_count != '0));

endmodule

// File: tb/test_uart_rx_errchk.sv
module test_uart_rx_errchk;

   localparam int OVS       = 16;
   localparam int DEPTH     = 4;
   localparam int TICK_DIV  = 4;
   localparam int BIT_CLKS  = OVS * TICK_DIV;
   localparam int CNT_W     = $clog2(DEPTH + 1);
   localparam int N_VEC     = 16;
   localparam int WDOG_MAX  = 150000;

   // vector: data[18:11] pen[10] mode[9:8] two[7] pbit[6] s1[5] s2[4] ep[3] ef[2] eb[1] spare[0]
   localparam logic [18:0] VEC [N_VEC] = '{
      {8'h55, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R2
      {8'hA3, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R2
      {8'h00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R4
      {8'h01, 1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 odd ok
      {8'h01, 1'b1, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 odd bad
      {8'h03, 1'b1, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 even ok
      {8'h07, 1'b1, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 even bad
      {8'h0F, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 zero ok
      {8'h0F, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 zero bad
      {8'hF0, 1'b1, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 one ok
      {8'hF0, 1'b1, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 one bad
      {8'h3C, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 ok
      {8'h3C, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R5 second low
      {8'h81, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R6
      {8'h00, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R7 with parity
      {8'h00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}  // R7 no parity
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             os_tick = 1'b0;
   logic             rx_in = 1'b1;
   logic             rx_disable = 1'b0;
   logic             par_en = 1'b0;
   logic [1:0]       par_mode = 2'b00;
   logic             two_stop = 1'b0;
   logic             pop = 1'b0;
   logic [7:0]       rd_data;
   logic             rd_perr, rd_ferr, rd_brk;
   logic [CNT_W-1:0] rx_count;
   logic [7:0]       fifo_status;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;

   always #5 clk = ~clk;

   uart_rx_errchk #(
      .OVS         (OVS),
      .FIFO_DEPTH  (DEPTH),
      .SYNC_STAGES (2)
   ) i_uart_rx_errchk (
      .clk         (clk),
      .rst_n       (rst_n),
      .os_tick     (os_tick),
      .rx_in       (rx_in),
      .rx_disable  (rx_disable),
      .par_en      (par_en),
      .par_mode    (par_mode),
      .two_stop    (two_stop),
      .pop         (pop),
      .rd_data     (rd_data),
      .rd_perr     (rd_perr),
      .rd_ferr     (rd_ferr),
      .rd_brk      (rd_brk),
      .rx_count    (rx_count),
      .fifo_status (fifo_status)
   );

   initial begin
      forever begin
         repeat (TICK_DIV - 1) @(negedge clk);
         os_tick = 1'b1;
         @(negedge clk);
         os_tick = 1'b0;
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles == WDOG_MAX) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp<%0d", cycles, WDOG_MAX);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
      end
   endtask

   task automatic hold_bit(input logic v);
      rx_in = v;
      repeat (BIT_CLKS) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input logic pen, input logic pb,
                       input logic two, input logic s1, input logic s2);
      hold_bit(1'b0);
      for (int i = 0; i < 8; i++) hold_bit(d[i]);
      if (pen) hold_bit(pb);
      hold_bit(s1);
      if (two) hold_bit(s2);
      hold_bit(1'b1);
      hold_bit(1'b1);
   endtask

   task automatic do_pop();
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      logic [18:0] v;
      repeat (4) @(negedge clk);
      // R1: reset state
      chk("R1 count", 32'(rx_count), 32'd0);
      chk("R1 status", 32'(fifo_status), 32'h00);
      chk("R1 rd", {21'd0, rd_data, rd_perr, rd_ferr, rd_brk}, 32'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // table walk: R2..R7, R11
      for (int k = 0; k < N_VEC; k++) begin
         v        = VEC[k];
         par_en   = v[10];
         par_mode = v[9:8];
         two_stop = v[7];
         send(v[18:11], v[10], v[6], v[7], v[5], v[4]);
         chk($sformatf("R2 vec%0d count", k), 32'(rx_count), 32'd1);
         chk($sformatf("R2 vec%0d data", k), 32'(rd_data), 32'(v[18:11]));
         chk($sformatf("R3 vec%0d perr", k), 32'(rd_perr), 32'(v[3]));
         chk($sformatf("R6 vec%0d ferr", k), 32'(rd_ferr), 32'(v[2]));
         chk($sformatf("R7 vec%0d brk", k), 32'(rd_brk), 32'(v[1]));
         chk($sformatf("R11 vec%0d status", k), 32'(fifo_status),
             32'({1'b0, v[1], v[2], v[3], 1'b1, 3'b000}));
         do_pop();
         chk($sformatf("R10 vec%0d drained", k), 32'(rx_count), 32'd0);
      end
      par_en   = 1'b0;
      par_mode = 2'b00;
      two_stop = 1'b0;

      // R7: long break gives one entry
      rx_in = 1'b0;
      repeat (30 * BIT_CLKS) @(negedge clk);
      hold_bit(1'b1);
      hold_bit(1'b1);
      chk("R7 long break count", 32'(rx_count), 32'd1);
      chk("R7 long break flags", {29'd0, rd_brk, rd_ferr, 1'b0}, 32'd6);
      chk("R7 long break data", 32'(rd_data), 32'd0);
      do_pop();

      // R8: short low glitch is rejected, next byte still received
      rx_in = 1'b0;
      repeat (2 * TICK_DIV) @(negedge clk);
      rx_in = 1'b1;
      repeat (20 * BIT_CLKS) @(negedge clk);
      chk("R8 glitch no entry", 32'(rx_count), 32'd0);
      send(8'h6E, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      chk("R8 after glitch data", 32'(rd_data), 32'h6E);
      do_pop();

      // R9: reception off discards
      rx_disable = 1'b1;
      send(8'h5A, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      chk("R9 disabled count", 32'(rx_count), 32'd0);
      chk("R9 disabled status", 32'(fifo_status), 32'h00);
      rx_disable = 1'b0;
      send(8'hC7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      chk("R9 re-enabled count", 32'(rx_count), 32'd1);
      do_pop();

      // R10: order and overflow drop
      send(8'h11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      send(8'h22, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      send(8'h33, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      send(8'h44, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      send(8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R10 full count", 32'(rx_count), 32'(DEPTH));
      for (int j = 0; j < DEPTH; j++) begin
         chk($sformatf("R10 order %0d", j), 32'(rd_data), 32'(8'h11 * (j + 1)));
         chk($sformatf("R10 order %0d ferr", j), 32'(rd_ferr), 32'd0);
         do_pop();
      end
      chk("R10 empty after drain", 32'(rx_count), 32'd0);
      chk("R11 empty status", 32'(fifo_status), 32'h00);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule